// File: doc/BRIEF.md
# LSB-first SPI control port

This block is the serial control port of a voice record/playback controller. A host acts as the four-wire SPI master and exchanges one 16-bit word with the block in each transaction. The port shifts in a command word from MOSI and shifts out a reply word on MISO at the same time. Both directions carry the least significant bit first. A completed command is presented to the rest of the controller as a 5-bit opcode, an 11-bit row address and a one-cycle strobe.

The port also keeps two event flags, end-of-message and overflow, which internal strobes set. While either flag is set, an active-low interrupt line is pulled low, modelling an open-drain pin: 0 pulls low and 1 releases the line to an external pull-up. Any transaction of exactly 16 bits clears both flags when the host deselects the port. The two flags occupy the two low bits of every reply word, so a read-interrupt transaction returns them to the host.

SCLK and SS are brought into the system clock domain through synchronisers, and their edges are detected there. MOSI is synchronised with the same depth, so each sampled bit lines up with its clock edge. SCLK may run at up to one quarter of the system clock rate.

Top module: `lsb_spi_ctrl_port`

## Requirements
- R1: After reset, irq_n_o is 1, cmd_valid_o is 0, and cmd_opcode_o and cmd_row_o are 0.
- R2: While ss_n_i is high, miso_oe_o is 0 and miso_o is 0 (high impedance). While ss_n_i is low, miso_oe_o is 1.
- R3: MOSI is taken on each rising SCLK edge, least significant bit first. The first bit received becomes bit 0 of the command word. After a 16-bit transaction, cmd_opcode_o holds word bits [4:0] and cmd_row_o holds word bits [15:5], and cmd_valid_o pulses for exactly one clock.
- R4: The reply word is loaded when the port is selected and is presented on MISO least significant bit first. Bit 0 is valid before the first rising SCLK edge, and the next bit appears after each falling SCLK edge. The reply word is {status_i, eom flag, ovf flag}: status_i occupies bits [15:2] and is taken at the moment of selection.
- R5: An eom_evt_i or ovf_evt_i pulse sets its flag. irq_n_o goes to 0 one clock later and stays at 0 until a clear.
- R6: When SS rises after exactly 16 rising SCLK edges, both flags are cleared and irq_n_o returns to 1.
- R7: A transaction with any other number of rising SCLK edges is ignored. It produces no cmd_valid_o pulse, it leaves cmd_opcode_o and cmd_row_o unchanged, and it does not clear the flags.
- R8: If an event pulse arrives in the same clock as a clear, that event's flag stays set and irq_n_o stays at 0. The other flag is still cleared.
- R9: Reply bit 0 is the overflow flag and reply bit 1 is the end-of-message flag, as they stood when the port was selected. A read-interrupt transaction therefore reports each flag on its own.
- R10: After a clear, a new event asserts the interrupt again, for every operation that ends with an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI serial clock from the host |
| ss_n_i | input | 1 | Active-low select from the host |
| mosi_i | input | 1 | Serial data from the host |
| eom_evt_i | input | 1 | One-cycle end-of-message event strobe |
| ovf_evt_i | input | 1 | One-cycle overflow event strobe |
| status_i | input | 14 | Status bits returned in reply bits [15:2] |
| miso_o | output | 1 | Serial reply data |
| miso_oe_o | output | 1 | MISO drive enable; 0 means high impedance |
| irq_n_o | output | 1 | Interrupt, 0 = pull low, 1 = release |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed command |
| cmd_opcode_o | output | 5 | Opcode of the last completed command |
| cmd_row_o | output | 11 | Row address of the last completed command |

## Verification
The assertions assume that SCLK and SS change no faster than the synchronisers can follow. Each SCLK level must last at least two system clocks, and SS must not toggle within a few clocks of an SCLK edge. They also assume that the event inputs are single-cycle strobes in the system clock domain. The stimulus holds every SCLK level for four clocks and leaves a margin of several clocks around each SS change. It places each event strobe either while the port is idle or, for the same-cycle case, on the exact clock in which the deselect is detected. The random stimulus mixes transaction lengths from 15 to 17 bits, random command and status words, and events with one flag, the other flag or both.

// File: rtl/spip_pkg.sv
package spip_pkg;

  localparam int unsigned FLAG_W = 2;

  // bit 1 = end-of-message, bit 0 = overflow; this order is the reply layout
  typedef struct packed {
    logic eom;
    logic ovf;
  } irq_flags_t;

  // clear first, then let any event of the same cycle set its flag again
  function automatic irq_flags_t flags_next(irq_flags_t cur, logic clr,
                                            logic eom_e, logic ovf_e);
    irq_flags_t n;
    n     = clr ? '0 : cur;
    n.eom = n.eom | eom_e;
    n.ovf = n.ovf | ovf_e;
    return n;
  endfunction

  function automatic int unsigned count_width(int unsigned bits);
    return $clog2(bits + 1);
  endfunction

endpackage

// File: rtl/spip_edge_sync.sv
module spip_edge_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      prev <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;

endmodule

// File: rtl/spip_rx_shift.sv
module spip_rx_shift #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mosi_i,
  input  logic         sel,
  input  logic         sel_start,
  input  logic         sel_end,
  input  logic         bit_rise,
  output logic         done,
  output logic [W-1:0] word
);
  import spip_pkg::*;

  localparam int unsigned CNT_W = count_width(W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

  logic [STAGES-1:0] mosi_chain;
  logic              mosi_q;
  logic [CNT_W-1:0]  cnt;
  logic [W-1:0]      shreg;
  logic              take_bit;

  // same depth as the SCLK path so each bit lines up with its edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mosi_chain <= '0;
    else        mosi_chain <= {mosi_chain[STAGES-2:0], mosi_i};
  end
  assign mosi_q   = mosi_chain[STAGES-1];
  assign take_bit = sel && bit_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else begin
      if (sel_start)                         cnt <= '0;
      else if (take_bit && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
      if (take_bit) shreg <= {mosi_q, shreg[W-1:1]};
    end
  end

  assign done = sel_end && (cnt == CNT_FULL);
  assign word = shreg;

  assert_bit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && !sel_start && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  assert_word_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_bit |=> (shreg[W-1] == $past(mosi_q)));

endmodule

// File: rtl/spip_tx_shift.sv
module spip_tx_shift #(
  parameter int unsigned W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         shift,
  input  logic [W-spip_pkg::FLAG_W-1:0] status,
  input  spip_pkg::irq_flags_t         flags,
  output logic                         bit_o
);
  import spip_pkg::*;

  logic [W-1:0] sh;

  function automatic logic [W-1:0] build_reply(logic [W-FLAG_W-1:0] st,
                                               irq_flags_t fl);
    return {st, fl};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= build_reply(status, flags);
    else if (shift) sh <= {1'b0, sh[W-1:1]};
  end

  assign bit_o = sh[0];

  assert_reply_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sh));

  assert_reply_ovf_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bit_o == $past(flags.ovf)));

endmodule

// File: rtl/spip_irq_latch.sv
module spip_irq_latch (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 eom_e,
  input  logic                 ovf_e,
  output spip_pkg::irq_flags_t flags,
  output logic                 irq_n_o
);
  import spip_pkg::*;

  irq_flags_t flg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else        flg <= flags_next(flg, clr, eom_e, ovf_e);
  end

  assign flags   = flg;
  assign irq_n_o = ~(flg.eom | flg.ovf);

  assert_evt_sets_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_e || ovf_e) |=> !irq_n_o);

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !eom_e && !ovf_e) |=> $stable(irq_n_o));

  assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !eom_e && !ovf_e) |=> irq_n_o);

  assert_evt_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && eom_e && !ovf_e) |=> (flags.eom && !flags.ovf));

endmodule

// File: rtl/lsb_spi_ctrl_port.sv
module lsb_spi_ctrl_port #(
  parameter int unsigned CMD_W       = 16,
  parameter int unsigned OPC_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sclk_i,
  input  logic                              ss_n_i,
  input  logic                              mosi_i,
  input  logic                              eom_evt_i,
  input  logic                              ovf_evt_i,
  input  logic [CMD_W-spip_pkg::FLAG_W-1:0] status_i,
  output logic                              miso_o,
  output logic                              miso_oe_o,
  output logic                              irq_n_o,
  output logic                              cmd_valid_o,
  output logic [OPC_W-1:0]                  cmd_opcode_o,
  output logic [CMD_W-OPC_W-1:0]            cmd_row_o
);
  import spip_pkg::*;

  localparam int unsigned ROW_W = CMD_W - OPC_W;

  // index 1 = select, index 0 = serial clock
  logic [1:0] pin_q, pin_rise, pin_fall;
  logic       sel, sel_start, sel_end, bit_rise, bit_fall;
  logic       word_done, tx_bit;
  logic [CMD_W-1:0] rx_word;
  irq_flags_t flags;

  spip_edge_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b10)) u_sync (
    .clk (clk), .rst_n (rst_n), .d ({ss_n_i, sclk_i}),
    .q (pin_q), .rise (pin_rise), .fall (pin_fall));

  assign sel       = ~pin_q[1];
  assign sel_start = pin_fall[1];
  assign sel_end   = pin_rise[1];
  assign bit_rise  = pin_rise[0];
  assign bit_fall  = pin_fall[0];

  spip_rx_shift #(.W(CMD_W), .STAGES(SYNC_STAGES)) u_rx (
    .clk (clk), .rst_n (rst_n), .mosi_i (mosi_i), .sel (sel),
    .sel_start (sel_start), .sel_end (sel_end), .bit_rise (bit_rise),
    .done (word_done), .word (rx_word));

  spip_tx_shift #(.W(CMD_W)) u_tx (
    .clk (clk), .rst_n (rst_n), .load (sel_start),
    .shift (sel && bit_fall), .status (status_i), .flags (flags),
    .bit_o (tx_bit));

  spip_irq_latch u_irq (
    .clk (clk), .rst_n (rst_n), .clr (word_done), .eom_e (eom_evt_i),
    .ovf_e (ovf_evt_i), .flags (flags), .irq_n_o (irq_n_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_o  <= 1'b0;
      cmd_opcode_o <= '0;
      cmd_row_o    <= '0;
    end else begin
      cmd_valid_o <= word_done;
      if (word_done) begin
        cmd_opcode_o <= rx_word[OPC_W-1:0];
        cmd_row_o    <= rx_word[CMD_W-1:OPC_W];
      end
    end
  end

  assign miso_oe_o = ~ss_n_i;
  assign miso_o    = miso_oe_o & tx_bit;

  assert_valid_after_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(sel_end));

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> ($stable(cmd_opcode_o) && $stable(cmd_row_o)));

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !eom_evt_i && !ovf_evt_i) |=> irq_n_o);

  initial begin
    assert_geometry_R3: assert (ROW_W > 0 && CMD_W > FLAG_W && SYNC_STAGES >= 2);
  end

endmodule

// File: tb/lsb_spi_ctrl_port_tb.sv
module lsb_spi_ctrl_port_tb_top;

  logic clk = 1'b0;
  logic rst_n, sclk, ss_n, mosi, eom_evt, ovf_evt;
  logic [13:0] status;
  logic miso, miso_oe, irq_n, cmd_valid;
  logic [4:0]  cmd_opcode;
  logic [10:0] cmd_row;

  int checks = 0, errors = 0, vcount = 0, exp_vcount = 0;
  bit finished = 0;
  logic m_eom = 0, m_ovf = 0;
  logic [4:0]  exp_opc = '0;
  logic [10:0] exp_row = '0;

  always #4 clk = ~clk;

  lsb_spi_ctrl_port dut_i (
    .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .ss_n_i (ss_n), .mosi_i (mosi),
    .eom_evt_i (eom_evt), .ovf_evt_i (ovf_evt), .status_i (status),
    .miso_o (miso), .miso_oe_o (miso_oe), .irq_n_o (irq_n),
    .cmd_valid_o (cmd_valid), .cmd_opcode_o (cmd_opcode), .cmd_row_o (cmd_row));

  always @(posedge clk) if (cmd_valid) vcount++;

  function automatic logic [15:0] exp_reply(logic [13:0] st, logic e, logic o);
    logic [15:0] r;
    r[15:2] = st;
    r[1]    = e;
    r[0]    = o;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(int nbits, logic [15:0] win, output logic [15:0] rep);
    rep = '0;
    @(negedge clk) ss_n = 1'b0;
    repeat (6) @(negedge clk);
    check(miso_oe == 1'b1, "R2", "oe while selected", miso_oe, 1);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? win[i] : 1'($urandom_range(1));
      repeat (4) @(negedge clk);
      if (i < 16) rep[i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ss_n = 1'b1;
  endtask

  task automatic pulse_evt(logic e, logic o);
    @(negedge clk);
    eom_evt = e; ovf_evt = o;
    @(negedge clk);
    eom_evt = 1'b0; ovf_evt = 1'b0;
    m_eom |= e; m_ovf |= o;
    check(irq_n == ~(m_eom | m_ovf), "R5", "irq after event", irq_n, ~(m_eom | m_ovf));
  endtask

  task automatic do_txn(int nbits, logic [15:0] win, logic [13:0] st, logic ce, logic co);
    logic [15:0] rep, expr, mask;
    status = st;
    expr = exp_reply(st, m_eom, m_ovf);
    xfer(nbits, win, rep);
    @(negedge clk);
    @(negedge clk);
    eom_evt = ce; ovf_evt = co;
    @(negedge clk);
    eom_evt = 1'b0; ovf_evt = 1'b0;
    repeat (4) @(negedge clk);
    if (nbits == 16) begin
      m_eom = 0; m_ovf = 0;
      exp_opc = win[4:0];
      exp_row = win[15:5];
      exp_vcount++;
    end
    m_eom |= ce; m_ovf |= co;
    mask = (nbits >= 16) ? 16'hFFFF : 16'((32'd1 << nbits) - 1);
    check((rep & mask) == (expr & mask), "R4/R9", "reply word", rep & mask, expr & mask);
    check(cmd_opcode == exp_opc, "R3/R7", "opcode", cmd_opcode, exp_opc);
    check(cmd_row == exp_row, "R3/R7", "row", cmd_row, exp_row);
    check(vcount == exp_vcount, "R3/R7", "valid pulses", vcount, exp_vcount);
    check(irq_n == ~(m_eom | m_ovf), "R6/R8", "irq after txn", irq_n, ~(m_eom | m_ovf));
    check(miso_oe == 1'b0 && miso == 1'b0, "R2", "hi-z when deselected", {miso_oe, miso}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nb;
    int unsigned pick;
    void'($urandom(32'd20240611));
    rst_n = 0; sclk = 0; ss_n = 1; mosi = 0; eom_evt = 0; ovf_evt = 0; status = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(irq_n == 1'b1, "R1", "irq reset", irq_n, 1);
    check(cmd_valid == 1'b0 && vcount == 0, "R1", "valid reset", vcount, 0);
    check(cmd_opcode == 0 && cmd_row == 0, "R1", "cmd reset", {cmd_row, cmd_opcode}, 0);
    check(miso_oe == 0 && miso == 0, "R2", "hi-z at reset", {miso_oe, miso}, 0);

    // plain command, no flags
    do_txn(16, 16'hA5C3, 14'h048D, 0, 0);
    // R5: overflow event holds the interrupt low
    pulse_evt(0, 1);
    repeat (20) @(negedge clk);
    check(irq_n == 1'b0, "R5", "irq held low", irq_n, 0);
    // R7: short and long transactions are ignored
    do_txn(12, 16'h0FFF, 14'h1555, 0, 0);
    do_txn(20, 16'h7E81, 14'h2AAA, 0, 0);
    // R9: overflow alone reported in bit 0, then R6 clear
    do_txn(16, 16'h000C, 14'h0000, 0, 0);
    // R10: a new event after the clear raises the interrupt again; eom alone in bit 1
    pulse_evt(1, 0);
    do_txn(16, 16'h800C, 14'h3FFF, 0, 0);
    // R8: eom arrives in the clearing cycle while ovf is set
    pulse_evt(0, 1);
    do_txn(16, 16'h1234, 14'h0101, 1, 0);
    check(irq_n == 1'b0, "R8", "event beats clear", irq_n, 0);
    do_txn(16, 16'h4321, 14'h0202, 0, 0);
    check(irq_n == 1'b1, "R10", "released after repeat", irq_n, 1);

    for (int it = 0; it < 30; it++) begin
      pick = $urandom_range(7);
      if (pick == 1) pulse_evt(1, 0);
      else if (pick == 2) pulse_evt(0, 1);
      else if (pick == 3) pulse_evt(1, 1);
      pick = $urandom_range(4);
      nb = (pick == 3) ? 15 : (pick == 4) ? 17 : 16;
      pick = $urandom_range(5);
      do_txn(nb, 16'($urandom), 14'($urandom), pick == 0, pick == 1);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule